// File: doc/BRIEF.md
# Phase-Shifted Hybrid Dimming PWM Generator

This block turns one brightness code into drive for a group of LED current-sink channels. Each channel gets an on/off PWM line, and all channels share one current-level code. A 3-bit threshold selector fixes the brightness below which dimming is done by pulse width. Above that level the sinks stay on and the current code follows brightness. Below it, the current is held at the threshold level and the duty cycle carries the rest of the dimming.

Channels that are enabled and not fault-disabled are spread evenly over one PWM period, so their turn-on edges never coincide. When a channel joins or leaves, the spacing is recomputed from the new active count. A fractional prescaler sets the PWM period rate from a 3-bit frequency code. Brightness, masks and threshold are sampled only at a period boundary, so the waveform never changes halfway through a period.

Top module: `hybrid_dim_pwm`

## Requirements
- R1: A BW-bit period counter advances by one on each tick and wraps after 2^BW ticks. A prescaler accumulates freq_sel_i+1 per clock modulo PDIV and issues a tick on each overflow, so the period lasts 2^BW*PDIV/(freq_sel_i+1) clocks. The frequency code acts at once and is not held until a boundary.
- R2: Threshold code 0 gives a threshold level T of 0. Code t from 1 to 7 gives T = 2^(BW-7+t). Code 7 therefore gives T = 2^BW.
- R3: When T is 0 or brightness >= T, every active channel is high for the whole period and cur_o equals the brightness.
- R4: When brightness < T, cur_o equals T and each active channel is high for brightness*2^BW/T ticks per period. cur_o never exceeds 2^BW.
- R5: An active channel of rank r, among N active channels, turns on at tick floor(r*2^BW/N) of the period. Its on-window wraps past the end of the period.
- R6: A channel is active when its chan_en_i bit is 1 and its fault_i bit is 0. Ranks count active channels by ascending index. Inactive channels stay low.
- R7: When no channel is active, all PWM lines stay low.
- R8: bright_i, chan_en_i, fault_i and thr_sel_i are captured only when the counter wraps. pwm_o and cur_o keep following the old values until that wrap.
- R9: Reset clears the counter and prescaler. pwm_o and cur_o stay 0 until the first wrap after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bright_i | input | BW | Brightness code |
| chan_en_i | input | NCH | Channel enable mask |
| fault_i | input | NCH | Per-channel fault-disable mask |
| thr_sel_i | input | 3 | Current/PWM threshold selector |
| freq_sel_i | input | 3 | PWM period rate selector |
| pwm_o | output | NCH | Per-channel PWM on/off lines |
| cur_o | output | BW+1 | Shared current-level code |

## Verification
Two events can fall on the same period boundary: the hybrid split moving to another threshold, and the re-phasing caused by a change in the enable or fault mask. The bench changes threshold, brightness, enable mask and fault mask together in the middle of a period. It then checks that the rest of that period keeps the old waveform. It also checks that the next period shows the new duty, the new current code and the new phase spacing all at once. Each tick of both periods is compared with values computed arithmetically from the requirements.

// File: rtl/hybrid_dim_pwm.sv
module hybrid_dim_pwm #(
  parameter int NCH  = 6,
  parameter int BW   = 12,
  parameter int PDIV = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BW-1:0]   bright_i,
  input  logic [NCH-1:0]  chan_en_i,
  input  logic [NCH-1:0]  fault_i,
  input  logic [2:0]      thr_sel_i,
  input  logic [2:0]      freq_sel_i,
  output logic [NCH-1:0]  pwm_o,
  output logic [BW:0]     cur_o
);
  localparam int RW = $clog2(NCH + 1);
  localparam int AW = $clog2(PDIV + 8) + 1;
  localparam int OW = BW + RW;

  function automatic logic [RW-1:0] pcnt(input logic [NCH-1:0] v);
    logic [RW-1:0] s;
    s = '0;
    for (int j = 0; j < NCH; j++) s = s + RW'(v[j]);
    return s;
  endfunction

  logic [AW-1:0]  acc_q, acc_sum;
  logic           tick, wrap;
  logic [BW-1:0]  cnt_q;

  assign acc_sum = acc_q + AW'(freq_sel_i) + AW'(1);
  assign tick    = acc_sum >= AW'(PDIV);
  assign wrap    = tick && (cnt_q == {BW{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= tick ? acc_sum - AW'(PDIV) : acc_sum;
      if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  logic [NCH-1:0] act_n, act_q;
  logic [RW-1:0]  n_act;
  logic [BW:0]    thr_lvl, cur_n;
  logic           full_n, full_q;
  logic [BW-1:0]  duty_n, duty_q;

  assign act_n = chan_en_i & ~fault_i;
  assign n_act = pcnt(act_n);

  always_comb begin
    if (thr_sel_i == 3'd0) thr_lvl = '0;
    else thr_lvl = (BW+1)'(1) << (BW - 7 + int'(thr_sel_i));
  end

  assign full_n = (thr_lvl == '0) || ({1'b0, bright_i} >= thr_lvl);
  assign duty_n = full_n ? '0 : BW'(bright_i << (7 - int'(thr_sel_i)));
  assign cur_n  = full_n ? {1'b0, bright_i} : thr_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= '0;
      full_q <= 1'b0;
      duty_q <= '0;
      cur_o  <= '0;
    end else if (wrap) begin
      act_q  <= act_n;
      full_q <= full_n;
      duty_q <= duty_n;
      cur_o  <= cur_n;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [RW-1:0] rank;
    logic [OW-1:0] num;
    logic [BW-1:0] off_n, off_q, pos;

    assign rank  = pcnt(act_n & NCH'((1 << k) - 1));
    assign num   = OW'(rank) << BW;
    assign off_n = (n_act == '0) ? '0 : BW'(num / OW'(n_act));

    always_ff @(posedge clk) begin
      if (rst) off_q <= '0;
      else if (wrap) off_q <= off_n;
    end

    assign pos      = cnt_q - off_q;
    assign pwm_o[k] = act_q[k] & (full_q | (pos < duty_q));
  end
endmodule

// File: rtl/hybrid_dim_pwm_chk.sv
module hybrid_dim_pwm_chk #(
  parameter int NCH  = 6,
  parameter int BW   = 12,
  parameter int PDIV = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           tick,
  input logic [BW-1:0]  cnt_q,
  input logic [NCH-1:0] act_q,
  input logic [NCH-1:0] pwm_o,
  input logic [BW:0]    cur_o
);
  localparam logic [BW-1:0] CMAX = {BW{1'b1}};
  localparam logic [BW:0]   FULL = (BW+1)'(1) << BW;

  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt_q == BW'($past(cnt_q) + 1'b1));

  p_cur_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(tick && cnt_q == CMAX) |=> $stable(cur_o));

  p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
    act_q == '0 |-> pwm_o == '0);

  p_inactive_low_r6: assert property (@(posedge clk) disable iff (rst)
    (pwm_o & ~act_q) == '0);

  p_cur_range_r4: assert property (@(posedge clk) disable iff (rst)
    cur_o <= FULL);
endmodule

bind hybrid_dim_pwm hybrid_dim_pwm_chk #(.NCH(NCH), .BW(BW), .PDIV(PDIV)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .cnt_q(cnt_q),
  .act_q(act_q), .pwm_o(pwm_o), .cur_o(cur_o)
);

// File: tb/hybrid_dim_pwm_tb_top.sv
`timescale 1ns/1ps
module hybrid_dim_pwm_tb_top;
  localparam int NCH = 6;
  localparam int BW  = 6;
  localparam int P   = 64;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [BW-1:0]  bright_i = '0;
  logic [NCH-1:0] chan_en_i = '0;
  logic [NCH-1:0] fault_i = '0;
  logic [2:0]     thr_sel_i = '0;
  logic [2:0]     freq_sel_i = 3'd7;
  logic [NCH-1:0] pwm_o;
  logic [BW:0]    cur_o;

  int checks = 0;
  int errors = 0;
  int ecount = 0;

  always #2 clk = ~clk;

  hybrid_dim_pwm #(.NCH(NCH), .BW(BW), .PDIV(8)) dut_i (
    .clk(clk), .rst(rst), .bright_i(bright_i), .chan_en_i(chan_en_i),
    .fault_i(fault_i), .thr_sel_i(thr_sel_i), .freq_sel_i(freq_sel_i),
    .pwm_o(pwm_o), .cur_o(cur_o)
  );

  function automatic int pc(int v);
    int s = 0;
    for (int j = 0; j < NCH; j++) s += (v >> j) & 1;
    return s;
  endfunction

  function automatic int thr_of(int thr);
    return (thr == 0) ? 0 : (1 << (thr - 1));
  endfunction

  function automatic int exp_pwm(int br, int thr, int en, int flt, int i);
    int act = en & ~flt & 63;
    int n = pc(act);
    int t = thr_of(thr);
    int full = (t == 0) || (br >= t);
    int duty = full ? 0 : (br * P) / t;
    int res = 0;
    if (n == 0) return 0;
    for (int k = 0; k < NCH; k++) begin
      if ((act >> k) & 1) begin
        int r = pc(act & ((1 << k) - 1));
        int off = (r * P) / n;
        int d = (i - off + P) % P;
        if (full || d < duty) res |= (1 << k);
      end
    end
    return res;
  endfunction

  function automatic int exp_cur(int br, int thr);
    int t = thr_of(thr);
    return ((t == 0) || (br >= t)) ? br : t;
  endfunction

  task automatic step();
    @(posedge clk);
    ecount++;
    @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic apply(int br, int thr, int en, int flt);
    bright_i  = BW'(br);
    thr_sel_i = 3'(thr);
    chan_en_i = NCH'(en);
    fault_i   = NCH'(flt);
    do step(); while (ecount % P != 0);
  endtask

  task automatic run_period(int br, int thr, int en, int flt, string tag,
                            bit mid, int br2, int thr2, int en2, int flt2);
    int bad = 0;
    int bad_act = 0;
    int bad_exp = 0;
    for (int i = 0; i < P; i++) begin
      if (mid && i == P / 2) begin
        bright_i = BW'(br2); thr_sel_i = 3'(thr2);
        chan_en_i = NCH'(en2); fault_i = NCH'(flt2);
      end
      if (int'(pwm_o) != exp_pwm(br, thr, en, flt, i) && bad == 0) begin
        bad = 1;
        bad_act = int'(pwm_o);
        bad_exp = exp_pwm(br, thr, en, flt, i);
      end
      if (int'(cur_o) != exp_cur(br, thr) && bad == 0) begin
        bad = 2;
        bad_act = int'(cur_o);
        bad_exp = exp_cur(br, thr);
      end
      if (i < P - 1) step();
    end
    check(bad == 0, tag, bad_act, bad_exp);
  endtask

  task automatic rise_gap(output int gap);
    logic prev;
    gap = 0;
    prev = pwm_o[0];
    for (int n = 0; n < 4000; n++) begin
      step();
      gap++;
      if (!prev && pwm_o[0]) return;
      prev = pwm_o[0];
    end
    gap = -1;
  endtask

  initial begin
    int bad;
    int g;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    bad = 0;
    for (int i = 0; i < P; i++) begin
      if (pwm_o != '0 || cur_o != '0) bad = 1;
      if (i < P - 1) step();
    end
    check(bad == 0, "R9 reset state", int'({pwm_o, cur_o}), 0);

    for (int thr = 0; thr < 8; thr++)
      for (int br = 0; br < P; br++) begin
        apply(br, thr, 63, 0);
        run_period(br, thr, 63, 0, "R2 R3 R4 R5 split sweep", 0, 0, 0, 0, 0);
      end

    for (int en = 0; en < 64; en++) begin
      apply(20, 7, en, 0);
      run_period(20, 7, en, 0, "R5 R6 R7 enable sweep", 0, 0, 0, 0, 0);
    end

    for (int f = 0; f < 64; f += 5) begin
      apply(9, 5, 63, f);
      run_period(9, 5, 63, f, "R6 fault removal", 0, 0, 0, 0, 0);
    end

    apply(40, 0, 63, 0);
    run_period(40, 0, 63, 0, "R8 old config kept", 1, 3, 6, 45, 4);
    step();
    run_period(3, 6, 45, 4, "R8 R4 R5 new config", 0, 0, 0, 0, 0);

    apply(5, 4, 21, 0);
    run_period(5, 4, 21, 0, "R8 old config kept", 1, 60, 2, 63, 33);
    step();
    run_period(60, 2, 63, 33, "R8 R3 R6 new config", 0, 0, 0, 0, 0);

    apply(0, 3, 63, 0);
    run_period(0, 3, 63, 0, "R4 zero brightness", 0, 0, 0, 0, 0);

    apply(63, 7, 63, 63);
    run_period(63, 7, 63, 63, "R7 all faulted", 0, 0, 0, 0, 0);

    for (int fi = 0; fi < 4; fi++) begin
      int f = (fi == 3) ? 7 : (1 << fi) - 1;
      freq_sel_i = 3'(f);
      bright_i = BW'(1); thr_sel_i = 3'd7; chan_en_i = NCH'(1); fault_i = '0;
      rise_gap(g);
      rise_gap(g);
      check(g == (P * 8) / (f + 1), "R1 period length", g, (P * 8) / (f + 1));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(190000 * 4);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule